// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block sits on the host side of a four-wire serial link to a 12-bit successive-approximation converter that has four single-ended inputs. One accepted request selects an input and a clocking style. The block then pulls chip select low and sends an 8-bit command word on the data line. It clocks the converter until the 12-bit result has been shifted back, releases chip select, and presents the input number and result on a response port. The serial clock comes from the system clock through a divider, so both of its phases last `HALF_DIV` system cycles.

Two clocking styles are supported. In the clock-paced style, the serial clock itself paces the conversion. The sequencer runs a fixed count of serial clocks: eight clocks for the command, `EXT_SKIP` idle clocks, and twelve capture clocks. In the self-timed style, the serial clock is parked low after the command. The sequencer waits for a rising edge on the converter's strobe line, and a programmable timeout bounds that wait. When the limit is reached, the conversion is abandoned and an error response is returned.

The request port accepts a transfer when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the block is idle with no response pending. The response port holds `rsp_valid` and all response fields steady until `rsp_ready` is seen high at an edge. While a response is held, no new request is accepted, so back-pressure on the response side stalls the request side.

Top module: `adc_sar_host`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `req_ready` is 1 and `rsp_valid` is 0. Chip select stays high whenever the block is idle.
- R2: The command word is sent most significant bit first. From bit 7 down to bit 0 it is: bit 7 a start bit of 1, bits 6:5 the input number, bits 4:2 the `CFG_BITS` parameter (default 110), and bits 1:0 the clock style (11 for clock-paced, 10 for self-timed). `adc_din` changes only while `adc_sclk` is low and is steady through every high phase.
- R3: Each high phase and each low phase of `adc_sclk` lasts exactly `HALF_DIV` system cycles (default 13, which gives 1.92 MHz from 50 MHz). The first rising edge comes `HALF_DIV` cycles after chip select falls.
- R4: In the clock-paced style, a transfer has exactly 21 rising edges. Rise 9 is idle. `adc_dout` is captured on rises 10 to 21, most significant bit first. The strobe line is ignored.
- R5: In the self-timed style, `adc_sclk` stays low after the eighth clock until the synchronised strobe rises. Exactly 12 more clocks follow, and the result is captured on their rising edges, most significant bit first.
- R6: In the self-timed style, if no strobe rise arrives within `TIMEOUT_CYC` cycles, chip select rises with no further clocks. The response then carries `rsp_err`=1 and `rsp_data`=0, and the next request converts normally.
- R7: Chip select rises on the edge of the final falling serial edge, before `rsp_valid` goes high. `adc_sclk` is low whenever chip select is high.
- R8: `rsp_valid` and every response field stay unchanged until `rsp_ready` is taken. `req_ready` stays low from acceptance until the response has been taken.
- R9: A request held on the request port while a transfer is under way has no effect on the command sent or on the response of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken at this edge if offered |
| req_chan | input | CH_W | Input number to convert |
| req_int_clk | input | 1 | 1 selects the self-timed style, 0 the clock-paced style |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_chan | output | CH_W | Input number of the response |
| rsp_data | output | RES_W | Conversion result (0 on timeout) |
| rsp_err | output | 1 | Strobe timeout occurred |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_din | output | 1 | Command data to converter |
| adc_dout | input | 1 | Result data from converter |
| adc_sstrb | input | 1 | Converter strobe |

## Verification
The bench checks the skipped ninth clock in the clock-paced style. A sequencer that captured on that clock would return every result shifted right by one bit, and one with a wrong clock count would report a rise total other than 21. In the self-timed style, it confirms that no serial clock occurs between the command and the strobe, which a free-running clock would violate by advancing the rise count before the strobe. For the missing strobe, it requires an error response with zero data, followed by a clean conversion; a sequencer without the timeout would hang. It also holds the response port stalled and keeps a second request asserted during a transfer. A design that dropped the response or accepted the second request early would show changed fields or a wrong input number.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_RES,
    ST_DONE
  } host_state_t;

  localparam int          MODE_W   = 2;
  localparam logic [1:0]  MODE_EXT = 2'b11;
  localparam logic [1:0]  MODE_INT = 2'b10;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q;
  logic             term;

  assign term = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = term && !sclk_q;
  assign fall_o = term &&  sclk_q;

endmodule

// File: rtl/adc_shift_unit.sv
module adc_shift_unit #(
  parameter int CMD_W = 8,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic             tx_step,
  input  logic             rx_step,
  input  logic             dout_i,
  output logic             din_o,
  output logic [RES_W-1:0] rx_o
);
  logic [CMD_W-1:0] tx_q;
  logic [RES_W-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= cmd_in;
    end else if (tx_step) begin
      tx_q <= {tx_q[CMD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (rx_step) begin
      rx_q <= {rx_q[RES_W-2:0], dout_i};
    end
  end

  assign din_o = tx_q[CMD_W-1];
  assign rx_o  = rx_q;

endmodule

// File: rtl/adc_strobe_watch.sv
module adc_strobe_watch #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  input  logic arm,
  output logic seen_o,
  output logic expire_o
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic [2:0]       sync_q;
  logic [TMR_W-1:0] tmr_q;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strb_i};
  end

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (!arm)   tmr_q <= '0;
    else if (!rise && tmr_q != TMR_LAST) tmr_q <= tmr_q + 1'b1;
  end

  assign seen_o   = arm && rise;
  assign expire_o = arm && !rise && (tmr_q == TMR_LAST);

endmodule

// File: rtl/adc_sar_host.sv
module adc_sar_host
  import adc_host_pkg::*;
#(
  parameter int               HALF_DIV    = 13,
  parameter int               TIMEOUT_CYC = 1024,
  parameter int               CH_W        = 2,
  parameter int               CFG_W       = 3,
  parameter logic [CFG_W-1:0] CFG_BITS    = 3'b110,
  parameter int               RES_W       = 12,
  parameter int               EXT_SKIP    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic             req_int_clk,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CH_W-1:0]  rsp_chan,
  output logic [RES_W-1:0] rsp_data,
  output logic             rsp_err,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout,
  input  logic             adc_sstrb
);
  localparam int CMD_W   = 1 + CH_W + CFG_W + MODE_W;
  localparam int TAIL_W  = EXT_SKIP + RES_W;
  localparam int RC_W    = $clog2(((CMD_W > TAIL_W) ? CMD_W : TAIL_W) + 1);

  host_state_t      state_q;
  logic             cs_n_q;
  logic             int_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] data_q;
  logic             err_q;
  logic [RC_W-1:0]  rises_q;

  logic             run, rise_p, fall_p;
  logic             load, tx_step, rx_step;
  logic             seen, expire;
  logic [RES_W-1:0] rx_word;
  logic [CMD_W-1:0] cmd_word;
  logic [RC_W-1:0]  skip_lim, done_lim;

  assign req_ready = (state_q == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign run       = (state_q == ST_CMD) || (state_q == ST_RES);
  assign cmd_word  = {1'b1, req_chan, CFG_BITS, (req_int_clk ? MODE_INT : MODE_EXT)};
  assign skip_lim  = int_q ? '0 : RC_W'(EXT_SKIP);
  assign done_lim  = skip_lim + RC_W'(RES_W);
  assign tx_step   = (state_q == ST_CMD) && fall_p;
  assign rx_step   = (state_q == ST_RES) && rise_p && (rises_q >= skip_lim);

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sclk_o (adc_sclk),
    .rise_o (rise_p),
    .fall_o (fall_p)
  );

  adc_shift_unit #(.CMD_W(CMD_W), .RES_W(RES_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .cmd_in  (cmd_word),
    .tx_step (tx_step),
    .rx_step (rx_step),
    .dout_i  (adc_dout),
    .din_o   (adc_din),
    .rx_o    (rx_word)
  );

  adc_strobe_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_strb (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_i   (adc_sstrb),
    .arm      (state_q == ST_WAIT),
    .seen_o   (seen),
    .expire_o (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      int_q   <= 1'b0;
      chan_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      rises_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cs_n_q  <= 1'b0;
            int_q   <= req_int_clk;
            chan_q  <= req_chan;
            rises_q <= '0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (rise_p) rises_q <= rises_q + 1'b1;
          if (fall_p && rises_q == RC_W'(CMD_W)) begin
            rises_q <= '0;
            state_q <= int_q ? ST_WAIT : ST_RES;
          end
        end
        ST_WAIT: begin
          if (seen) begin
            state_q <= ST_RES;
          end else if (expire) begin
            cs_n_q  <= 1'b1;
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_RES: begin
          if (rise_p) rises_q <= rises_q + 1'b1;
          if (fall_p && rises_q == done_lim) begin
            cs_n_q  <= 1'b1;
            err_q   <= 1'b0;
            data_q  <= rx_word;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_n  = cs_n_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_chan  = chan_q;
  assign rsp_data  = data_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/adc_sar_host_chk.sv
module adc_sar_host_chk #(
  parameter int HALF_DIV = 13,
  parameter int CH_W     = 2,
  parameter int RES_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CH_W-1:0]  rsp_chan,
  input logic [RES_W-1:0] rsp_data,
  input logic             rsp_err,
  input logic             adc_cs_n,
  input logic             adc_sclk,
  input logic             adc_din
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (adc_sclk) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_cs_n);

  a_r7_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  a_r7_cs_high_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> adc_cs_n);

  a_r2_din_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_din));

  a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> (hi_cnt == 16'(HALF_DIV)));

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                   && $stable(rsp_chan) && $stable(rsp_err)));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n || rsp_valid) |-> !req_ready);

  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

endmodule

bind adc_sar_host adc_sar_host_chk #(
  .HALF_DIV (HALF_DIV),
  .CH_W     (CH_W),
  .RES_W    (RES_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_chan  (rsp_chan),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_din   (adc_din)
);

// File: tb/adc_sar_host_tb_top.sv
`timescale 1ns/1ps
module adc_sar_host_tb_top;
  localparam int HALF = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = 2'd0;
  logic        req_int_clk = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_chan;
  logic [11:0] rsp_data;
  logic        rsp_err;
  logic        adc_cs_n, adc_sclk, adc_din, adc_dout, adc_sstrb;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_sar_host dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_int_clk(req_int_clk),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_chan(rsp_chan),
    .rsp_data(rsp_data), .rsp_err(rsp_err),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .adc_sstrb(adc_sstrb)
  );

  // ---------------- converter model ----------------
  logic [11:0] m_val [4];
  int          m_delay = 200;
  logic [7:0]  m_sh = '0;
  logic [7:0]  m_cmd_last = '0;
  logic        m_int = 1'b0;
  logic [11:0] m_word = '0;
  int          m_rises = 0;
  int          m_last_rises = 0;
  int          m_falls = 0;
  logic        m_q = 1'b0;
  logic        m_sstrb = 1'b0;
  int          m_tmr = 0;
  logic        m_strb_done = 1'b0;
  int          m_rises_at_strb = 0;

  always @(posedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      if (m_rises != 0) m_last_rises <= m_rises;
      m_rises <= 0;
      m_int   <= 1'b0;
    end else begin
      m_rises <= m_rises + 1;
      if (m_rises < 8) m_sh <= {m_sh[6:0], adc_din};
      if (m_rises == 7) begin
        m_cmd_last <= {m_sh[6:0], adc_din};
        m_int      <= ({m_sh[0], adc_din} == 2'b10);
        m_word     <= m_val[m_sh[5:4]];
      end
    end
  end

  always @(negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      m_falls <= 0;
      m_q     <= 1'b0;
    end else begin
      m_falls <= m_falls + 1;
      if (!m_int && (m_falls + 1) >= 9 && (m_falls + 1) <= 20) m_q <= m_word[19 - m_falls];
      if ( m_int && (m_falls + 1) >= 9 && (m_falls + 1) <= 19) m_q <= m_word[18 - m_falls];
    end
  end

  assign adc_dout  = (m_int && m_falls == 8) ? m_word[11] : m_q;
  assign adc_sstrb = m_sstrb;

  always @(posedge clk) begin
    if (adc_cs_n) begin
      m_sstrb     <= 1'b0;
      m_tmr       <= 0;
      m_strb_done <= 1'b0;
    end else if (!m_int) begin
      m_sstrb <= (m_rises == 8);
    end else if (!m_strb_done) begin
      if (m_tmr < m_delay) begin
        m_sstrb <= 1'b0;
        m_tmr   <= m_tmr + 1;
      end else begin
        m_sstrb         <= 1'b1;
        m_strb_done     <= 1'b1;
        m_rises_at_strb <= m_rises;
      end
    end
  end

  // ---------------- serial clock phase measurement ----------------
  logic prv_sclk = 1'b0, prv_cs = 1'b1;
  int   seg = 0;
  int   hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;

  always @(posedge clk) begin
    prv_sclk <= adc_sclk;
    prv_cs   <= adc_cs_n;
    if (!adc_cs_n && prv_cs) begin
      hi_min <= 1000000; hi_max <= 0; lo_min <= 1000000; lo_max <= 0;
    end
    if (adc_sclk != prv_sclk) begin
      if (prv_sclk) begin
        if (seg < hi_min) hi_min <= seg;
        if (seg > hi_max) hi_max <= seg;
      end else begin
        if (seg < lo_min) lo_min <= seg;
        if (seg > lo_max) lo_max <= seg;
      end
      seg <= 1;
    end else begin
      seg <= seg + 1;
    end
    if (adc_cs_n) seg <= 0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [1:0] ch, input bit intm);
    return {1'b1, ch, 3'b110, (intm ? 2'b10 : 2'b11)};
  endfunction

  task automatic issue(input logic [1:0] ch, input bit intm);
    @(negedge clk);
    req_valid   = 1'b1;
    req_chan    = ch;
    req_int_clk = intm;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic wait_rsp(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic take_rsp();
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(adc_cs_n == 1'b1, "R1", "cs_n after reset", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1", "sclk after reset", int'(adc_sclk), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_ext(input logic [1:0] ch, input logic [11:0] val);
    bit ok;
    m_val[ch] = val;
    issue(ch, 1'b0);
    wait_rsp(ok);
    chk(ok, "R4", "ext response arrives", int'(ok), 1);
    chk(rsp_data == val, "R4", "ext result", int'(rsp_data), int'(val));
    chk(rsp_chan == ch && !rsp_err, "R4", "ext chan/err", int'(rsp_chan), int'(ch));
    chk(m_cmd_last == exp_cmd(ch, 1'b0), "R2", "ext command word",
        int'(m_cmd_last), int'(exp_cmd(ch, 1'b0)));
    chk(m_last_rises == 21, "R4", "ext rise count", m_last_rises, 21);
    chk(hi_min == HALF && hi_max == HALF, "R3", "high phase", hi_max, HALF);
    chk(lo_min == HALF && lo_max == HALF, "R3", "low phase incl. cs setup", lo_max, HALF);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R7", "cs high at response",
        int'(adc_cs_n), 1);
    take_rsp();
  endtask

  task automatic t_int(input logic [1:0] ch, input logic [11:0] val, input int dly);
    bit ok;
    m_val[ch] = val;
    m_delay   = dly;
    issue(ch, 1'b1);
    wait_rsp(ok);
    chk(ok, "R5", "int response arrives", int'(ok), 1);
    chk(rsp_data == val, "R5", "int result", int'(rsp_data), int'(val));
    chk(rsp_chan == ch && !rsp_err, "R5", "int chan/err", int'(rsp_chan), int'(ch));
    chk(m_cmd_last == exp_cmd(ch, 1'b1), "R2", "int command word",
        int'(m_cmd_last), int'(exp_cmd(ch, 1'b1)));
    chk(m_rises_at_strb == 8, "R5", "no clocks while waiting", m_rises_at_strb, 8);
    chk(m_last_rises == 20, "R5", "int rise count", m_last_rises, 20);
    chk(hi_min == HALF && hi_max == HALF, "R3", "int high phase", hi_max, HALF);
    take_rsp();
  endtask

  task automatic t_timeout();
    bit ok;
    m_val[2] = 12'hABC;
    m_delay  = 1000000;
    issue(2'd2, 1'b1);
    wait_rsp(ok);
    chk(ok, "R6", "timeout response arrives", int'(ok), 1);
    chk(rsp_err == 1'b1, "R6", "error flag", int'(rsp_err), 1);
    chk(rsp_data == 12'h000, "R6", "data zero on timeout", int'(rsp_data), 0);
    chk(adc_cs_n == 1'b1, "R6", "cs released", int'(adc_cs_n), 1);
    chk(m_last_rises == 8, "R6", "no clocks after abort", m_last_rises, 8);
    take_rsp();
    t_int(2'd1, 12'h5A3, 150);
  endtask

  task automatic t_stall_and_busy();
    bit ok;
    logic [11:0] held;
    m_val[1] = 12'h3C7;
    m_val[2] = 12'h111;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd1; req_int_clk = 1'b0;
    @(negedge clk);
    req_chan = 2'd2;                 // R9: keep a different request asserted while busy
    wait_rsp(ok);
    req_valid = 1'b0;
    chk(ok && rsp_chan == 2'd1, "R9", "busy request ignored (chan)", int'(rsp_chan), 1);
    chk(rsp_data == 12'h3C7, "R9", "busy request ignored (data)", int'(rsp_data), 'h3C7);
    chk(m_cmd_last == exp_cmd(2'd1, 1'b0), "R9", "command unchanged",
        int'(m_cmd_last), int'(exp_cmd(2'd1, 1'b0)));
    held = rsp_data;
    repeat (40) @(negedge clk);
    chk(rsp_valid == 1'b1, "R8", "valid held under stall", int'(rsp_valid), 1);
    chk(rsp_data == held, "R8", "data held under stall", int'(rsp_data), int'(held));
    chk(req_ready == 1'b0, "R8", "not ready while response pending", int'(req_ready), 0);
    take_rsp();
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8", "released after take",
        int'(rsp_valid), 0);
  endtask

  initial begin
    m_val[0] = '0; m_val[1] = '0; m_val[2] = '0; m_val[3] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext(2'd0, 12'hA5C);
    t_ext(2'd3, 12'hFFF);
    t_ext(2'd1, 12'h000);
    t_ext(2'd2, 12'h801);
    t_int(2'd3, 12'h6D9, 200);
    t_int(2'd0, 12'hFFE, 60);
    t_timeout();
    t_stall_and_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule